// File: doc/BRIEF.md
# Cipher Key and Initialization-Vector Register Bank

This block is the register front end of a block-cipher accelerator. Software writes it over a simple 32-bit word-addressed bus. It holds a key of 128 or 256 bits in eight 32-bit words and an initialization vector, or counter, in four 32-bit words. A control word carries these settings:

- an engine-enable bit;
- a two-bit data-swap mode;
- an input DMA enable;
- a key-length select.

While the engine runs, key and IV contents are locked against software. The cipher core can still overwrite the IV through a parallel load strobe after every block. A read of an IV word always returns the value the core loaded most recently.

Words written to the data-input location pass through the swap path and are handed to the core one cycle later. The key and IV bypass the swap path entirely. When input DMA is enabled, a block request from the core raises a DMA request. The request is held until four data-input words have arrived.

Top module: `civ_regbank`

## Requirements
- R1: After reset, every key word, IV word and the control word are zero, `dma_req_o` and `din_valid_o` are low, and every read returns zero.
- R2: Key word n sits at word address 8+n (n = 0..7). A write there while the engine is disabled loads `key_o[32n+31:32n]` at the next clock edge, and a read of that address returns the same word.
- R3: A key write while control bit 0 (enable) is set leaves the key word unchanged.
- R4: When control bit 4 is 0 (128-bit key), `key_o[255:128]` reads as zero. Key words 4 to 7 keep their stored contents and still read back over the bus.
- R5: IV word n sits at word address 16+n (n = 0..3) and maps to `iv_o[32n+31:32n]`. A bus write to it takes effect only while enable is clear.
- R6: A pulse on `core_iv_upd_i` loads `core_iv_i` into all four IV words at that clock edge, and reads return the loaded value. If a software IV write falls in the same cycle, the core value wins.
- R7: The swap mode in control bits [2:1] has no effect on how key and IV words are written or read back.
- R8: A write to word address 1 (data input) produces `din_valid_o` for one cycle at the next edge. `din_word_o` carries the written word transformed by the swap mode in force at the write:
  - 0 leaves the word unchanged;
  - 1 exchanges the 16-bit halves;
  - 2 reverses the byte order;
  - 3 reverses the bit order.
- R9: With control bit 3 (input DMA enable) set, a `core_blk_req_i` pulse while no block is pending raises `dma_req_o` from the next cycle. The request stays high until the fourth data-input write and is low from the edge that accepts that write. A block request while one is already pending is ignored.
- R10: The control word at address 0 reads back in bits [4:0] with zeros above. The data-input address and every address other than 0, 8..19 read as zero, and writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| eng_en_o | output | 1 | Engine enable (control bit 0) |
| swap_mode_o | output | 2 | Data swap mode (control bits [2:1]) |
| key_long_o | output | 1 | 256-bit key selected (control bit 4) |
| key_o | output | 256 | Key to the cipher core |
| iv_o | output | 128 | IV/counter to the cipher core |
| core_iv_upd_i | input | 1 | Core loads a new IV value |
| core_iv_i | input | 128 | IV value from the core |
| core_blk_req_i | input | 1 | Core asks for a new input block |
| din_valid_o | output | 1 | Data-input word valid to the core |
| din_word_o | output | 32 | Swapped data-input word |
| dma_req_o | output | 1 | Input DMA request |

## Verification
A wrong lock or load decision in a key or IV word shows on `key_o` or `iv_o` at the very next clock edge. It also shows on a readback of that address in the same cycle, so the bench compares both against its model on every clock. A wrong block-word count in the DMA tracker shows as `dma_req_o` dropping too early, or staying high after the fourth word. Either case appears within four writes of the block request. A wrong swap selection shows on `din_word_o` one cycle after the data write, and only for the mode in use, so each mode is driven in turn.

// File: rtl/civ_pkg.sv
package civ_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned KEY_WORDS  = 8;
    localparam int unsigned IV_WORDS   = 4;
    localparam int unsigned BLK_WORDS  = 4;
    localparam int unsigned ADDR_W     = 6;

    localparam int unsigned ADR_CTRL   = 0;
    localparam int unsigned ADR_DIN    = 1;
    localparam int unsigned ADR_KEY0   = 8;
    localparam int unsigned ADR_IV0    = 16;

    localparam int unsigned CTRL_W     = 5;
    localparam int unsigned CTL_EN     = 0;
    localparam int unsigned CTL_SWAP   = 1;
    localparam int unsigned CTL_DMA    = 3;
    localparam int unsigned CTL_LONG   = 4;

    function automatic logic [31:0] swap_word(input logic [1:0] mode, input logic [31:0] w);
        logic [31:0] r;
        r = w;
        unique case (mode)
            2'd0: r = w;
            2'd1: r = {w[15:0], w[31:16]};
            2'd2: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
            default: begin
                for (int i = 0; i < 32; i++) r[i] = w[31-i];
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/civ_key_store.sv
module civ_key_store #(
    parameter int unsigned NW = 8,
    parameter int unsigned IW = $clog2(NW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              lock_i,
    input  logic              long_i,
    input  logic [IW-1:0]     rd_idx,
    output logic [31:0]       rd_data,
    output logic [NW*32-1:0]  key_o
);
    localparam int unsigned HALF = NW / 2;

    typedef struct packed {
        logic [NW-1:0][31:0] w;
    } key_st_t;

    key_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en && !lock_i) s_d.w[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NW; g++) begin : g_key
        if (g >= HALF) begin : g_upper
            assign key_o[g*32 +: 32] = long_i ? s_q.w[g] : 32'd0;
        end else begin : g_lower
            assign key_o[g*32 +: 32] = s_q.w[g];
        end
    end

    assign rd_data = s_q.w[rd_idx];
endmodule

// File: rtl/civ_iv_store.sv
module civ_iv_store #(
    parameter int unsigned NW = 4,
    parameter int unsigned IW = $clog2(NW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              lock_i,
    input  logic              upd_i,
    input  logic [NW*32-1:0]  upd_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [31:0]       rd_data,
    output logic [NW*32-1:0]  iv_o
);
    typedef struct packed {
        logic [NW-1:0][31:0] w;
    } iv_st_t;

    iv_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (upd_i) begin
            s_d.w = upd_data;
        end else if (wr_en && !lock_i) begin
            s_d.w[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign iv_o    = s_q.w;
    assign rd_data = s_q.w[rd_idx];
endmodule

// File: rtl/civ_dma_req.sv
module civ_dma_req #(
    parameter int unsigned BLK = 4,
    parameter int unsigned CW  = $clog2(BLK)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en_i,
    input  logic need_i,
    input  logic word_i,
    output logic req_o
);
    typedef struct packed {
        logic          pend;
        logic [CW-1:0] cnt;
    } dma_st_t;

    dma_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.pend) begin
            if (word_i) begin
                if (s_q.cnt == CW'(BLK - 1)) begin
                    s_d.pend = 1'b0;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end else if (need_i && dma_en_i) begin
            s_d.pend = 1'b1;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_o = s_q.pend && dma_en_i;
endmodule

// File: rtl/civ_regbank.sv
module civ_regbank
    import civ_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      eng_en_o,
    output logic [1:0]                swap_mode_o,
    output logic                      key_long_o,
    output logic [KEY_WORDS*32-1:0]   key_o,
    output logic [IV_WORDS*32-1:0]    iv_o,
    input  logic                      core_iv_upd_i,
    input  logic [IV_WORDS*32-1:0]    core_iv_i,
    input  logic                      core_blk_req_i,
    output logic                      din_valid_o,
    output logic [31:0]               din_word_o,
    output logic                      dma_req_o
);
    localparam int unsigned KIW = $clog2(KEY_WORDS);
    localparam int unsigned VIW = $clog2(IV_WORDS);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              din_v;
        logic [31:0]       din_w;
    } top_st_t;

    top_st_t s_d, s_q;

    logic              hit_ctrl, hit_din, hit_key, hit_iv;
    logic [ADDR_W-1:0] key_off, iv_off;
    logic [31:0]       key_rd, iv_rd;

    assign hit_ctrl = (bus_addr == ADDR_W'(ADR_CTRL));
    assign hit_din  = (bus_addr == ADDR_W'(ADR_DIN));
    assign hit_key  = (bus_addr >= ADDR_W'(ADR_KEY0)) &&
                      (bus_addr <  ADDR_W'(ADR_KEY0 + KEY_WORDS));
    assign hit_iv   = (bus_addr >= ADDR_W'(ADR_IV0)) &&
                      (bus_addr <  ADDR_W'(ADR_IV0 + IV_WORDS));
    assign key_off  = bus_addr - ADDR_W'(ADR_KEY0);
    assign iv_off   = bus_addr - ADDR_W'(ADR_IV0);

    always_comb begin
        s_d       = s_q;
        s_d.din_v = 1'b0;
        if (bus_we && hit_ctrl) s_d.ctrl = bus_wdata[CTRL_W-1:0];
        if (bus_we && hit_din) begin
            s_d.din_v = 1'b1;
            s_d.din_w = swap_word(s_q.ctrl[CTL_SWAP +: 2], bus_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    civ_key_store #(.NW(KEY_WORDS)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && hit_key),
        .wr_idx  (key_off[KIW-1:0]),
        .wr_data (bus_wdata),
        .lock_i  (s_q.ctrl[CTL_EN]),
        .long_i  (s_q.ctrl[CTL_LONG]),
        .rd_idx  (key_off[KIW-1:0]),
        .rd_data (key_rd),
        .key_o   (key_o)
    );

    civ_iv_store #(.NW(IV_WORDS)) u_iv (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we && hit_iv),
        .wr_idx   (iv_off[VIW-1:0]),
        .wr_data  (bus_wdata),
        .lock_i   (s_q.ctrl[CTL_EN]),
        .upd_i    (core_iv_upd_i),
        .upd_data (core_iv_i),
        .rd_idx   (iv_off[VIW-1:0]),
        .rd_data  (iv_rd),
        .iv_o     (iv_o)
    );

    civ_dma_req #(.BLK(BLK_WORDS)) u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_en_i (s_q.ctrl[CTL_DMA]),
        .need_i   (core_blk_req_i),
        .word_i   (bus_we && hit_din),
        .req_o    (dma_req_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl)     bus_rdata = {{(32-CTRL_W){1'b0}}, s_q.ctrl};
        else if (hit_key) bus_rdata = key_rd;
        else if (hit_iv)  bus_rdata = iv_rd;
    end

    assign eng_en_o    = s_q.ctrl[CTL_EN];
    assign swap_mode_o = s_q.ctrl[CTL_SWAP +: 2];
    assign key_long_o  = s_q.ctrl[CTL_LONG];
    assign din_valid_o = s_q.din_v;
    assign din_word_o  = s_q.din_w;
endmodule

// File: rtl/civ_regbank_chk.sv
module civ_regbank_chk
    import civ_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [31:0]             bus_rdata,
    input logic                    eng_en_o,
    input logic                    key_long_o,
    input logic [KEY_WORDS*32-1:0] key_o,
    input logic [IV_WORDS*32-1:0]  iv_o,
    input logic                    core_iv_upd_i,
    input logic [IV_WORDS*32-1:0]  core_iv_i
);
    localparam int unsigned HB = KEY_WORDS * 16;

    logic readable;
    assign readable = (bus_addr == 6'd0) ||
                      ((bus_addr >= 6'd8) && (bus_addr <= 6'd19));

    // R3: key frozen while engine enabled
    a_r3_key_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eng_en_o) && $stable(key_long_o)) |-> $stable(key_o));

    // R4: upper half of a short key is zero
    a_r4_short_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !key_long_o |-> (key_o[KEY_WORDS*32-1:HB] == '0));

    // R5: IV frozen against software while enabled
    a_r5_iv_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eng_en_o) && !$past(core_iv_upd_i)) |-> $stable(iv_o));

    // R6: core load lands on the next edge
    a_r6_core_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(core_iv_upd_i) |-> (iv_o == $past(core_iv_i)));

    // R10: unmapped and data-input addresses read zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !readable |-> (bus_rdata == 32'd0));
endmodule

bind civ_regbank civ_regbank_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .eng_en_o      (eng_en_o),
    .key_long_o    (key_long_o),
    .key_o         (key_o),
    .iv_o          (iv_o),
    .core_iv_upd_i (core_iv_upd_i),
    .core_iv_i     (core_iv_i)
);

// File: tb/sim_civ_regbank.sv
`timescale 1ns/1ps
module sim_civ_regbank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         eng_en_o, key_long_o, din_valid_o, dma_req_o;
    logic [1:0]   swap_mode_o;
    logic [255:0] key_o;
    logic [127:0] iv_o;
    logic         core_iv_upd_i = 1'b0;
    logic [127:0] core_iv_i = '0;
    logic         core_blk_req_i = 1'b0;
    logic [31:0]  din_word_o;

    int errors = 0;
    int checks = 0;

    // reference model
    logic [31:0] mk [8];
    logic [31:0] mi [4];
    logic [4:0]  mctl;
    logic        mpend, mdv;
    int          mcnt;
    logic [31:0] mdw;

    always #4 clk = ~clk;

    civ_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_en_o(eng_en_o),
        .swap_mode_o(swap_mode_o), .key_long_o(key_long_o), .key_o(key_o),
        .iv_o(iv_o), .core_iv_upd_i(core_iv_upd_i), .core_iv_i(core_iv_i),
        .core_blk_req_i(core_blk_req_i), .din_valid_o(din_valid_o),
        .din_word_o(din_word_o), .dma_req_o(dma_req_o)
    );

    function automatic logic [31:0] ref_swap(input logic [1:0] m, input logic [31:0] w);
        logic [31:0] r;
        case (m)
            2'd0: r = w;
            2'd1: r = {w[15:0], w[31:16]};
            2'd2: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
            default: for (int b = 0; b < 32; b++) r[31-b] = w[b];
        endcase
        return r;
    endfunction

    function automatic logic [31:0] mread(input int a);
        if (a == 0) return {27'd0, mctl};
        if (a >= 8 && a < 16) return mk[a-8];
        if (a >= 16 && a < 20) return mi[a-16];
        return 32'd0;
    endfunction

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) mk[i] = '0;
        for (int i = 0; i < 4; i++) mi[i] = '0;
        mctl = '0; mpend = 1'b0; mcnt = 0; mdv = 1'b0; mdw = '0;
    endtask

    task automatic model_step();
        int a;
        logic old_en;
        a = int'(bus_addr);
        old_en = mctl[0];
        mdv = bus_we && a == 1;
        if (mdv) mdw = ref_swap(mctl[2:1], bus_wdata);
        if (mpend) begin
            if (bus_we && a == 1) begin
                mcnt++;
                if (mcnt == 4) begin mpend = 1'b0; mcnt = 0; end
            end
        end else if (core_blk_req_i && mctl[3]) begin
            mpend = 1'b1; mcnt = 0;
        end
        if (bus_we && a >= 8 && a < 16 && !old_en) mk[a-8] = bus_wdata;
        if (core_iv_upd_i) begin
            for (int i = 0; i < 4; i++) mi[i] = core_iv_i[i*32 +: 32];
        end else if (bus_we && a >= 16 && a < 20 && !old_en) begin
            mi[a-16] = bus_wdata;
        end
        if (bus_we && a == 0) mctl = bus_wdata[4:0];
    endtask

    task automatic compare_all();
        logic [255:0] ek;
        logic [127:0] ei;
        for (int i = 0; i < 8; i++) ek[i*32 +: 32] = (i >= 4 && !mctl[4]) ? 32'd0 : mk[i];
        for (int i = 0; i < 4; i++) ei[i*32 +: 32] = mi[i];
        chk("R2 R4 key_o", key_o, ek);
        chk("R5 R6 iv_o", {128'd0, iv_o}, {128'd0, ei});
        chk("R9 dma_req_o", {255'd0, dma_req_o}, {255'd0, mpend && mctl[3]});
        chk("R10 ctrl outs", {252'd0, key_long_o, swap_mode_o, eng_en_o},
            {252'd0, mctl[4], mctl[2:1], mctl[0]});
        chk("R8 din_valid_o", {255'd0, din_valid_o}, {255'd0, mdv});
        if (mdv) chk("R8 din_word_o", {224'd0, din_word_o}, {224'd0, mdw});
    endtask

    task automatic cyc(input logic we, input int a, input logic [31:0] wd,
                       input logic upd, input logic [127:0] ivin, input logic blk);
        bus_we = we; bus_addr = 6'(a); bus_wdata = wd;
        core_iv_upd_i = upd; core_iv_i = ivin; core_blk_req_i = blk;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        bus_we = 1'b0; core_iv_upd_i = 1'b0; core_blk_req_i = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] wd);
        cyc(1'b1, a, wd, 1'b0, '0, 1'b0);
    endtask

    task automatic idle();
        cyc(1'b0, 0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic rd(input string tag, input int a);
        bus_we = 1'b0; bus_addr = 6'(a);
        #1;
        chk(tag, {224'd0, bus_rdata}, {224'd0, mread(a)});
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        compare_all();
        rd("R1 reset ctrl", 0);
        rd("R1 reset key0", 8);
        rd("R1 reset iv3", 19);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R2 long key, every word
        wr(0, 32'h10);
        for (int n = 0; n < 8; n++) wr(8 + n, 32'hA0000000 + n * 32'h01010101);
        for (int n = 0; n < 8; n++) rd("R2 key readback", 8 + n);

        // R7 swap mode does not touch key/IV
        wr(0, 32'h16);
        wr(9, 32'h12345678);
        wr(17, 32'hCAFEF00D);
        rd("R7 key under swap", 9);
        rd("R7 iv under swap", 17);
        wr(0, 32'h14);
        wr(10, 32'h80000001);
        rd("R7 key under byte swap", 10);

        // R4 short key
        wr(0, 32'h00);
        idle();
        rd("R4 upper word kept", 12);
        rd("R4 upper word kept", 15);

        // R5 IV writes
        for (int n = 0; n < 4; n++) wr(16 + n, 32'h5000_0000 + n);
        for (int n = 0; n < 4; n++) rd("R5 iv readback", 16 + n);

        // R3 R5 lock while enabled
        wr(0, 32'h11);
        wr(8, 32'hDEADBEEF);
        rd("R3 key write ignored", 8);
        wr(16, 32'hDEADBEEF);
        rd("R5 iv write ignored", 16);

        // R6 core update while enabled with blocked write
        cyc(1'b1, 18, 32'h0BAD0BAD, 1'b1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b0);
        for (int n = 0; n < 4; n++) rd("R6 live counter", 16 + n);
        // R6 core wins over write while disabled
        wr(0, 32'h10);
        cyc(1'b1, 16, 32'h77777777, 1'b1, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 1'b0);
        rd("R6 core wins", 16);
        wr(16, 32'h99999999);
        rd("R5 write after disable", 16);

        // R8 swap modes on data input
        for (int m = 0; m < 4; m++) begin
            wr(0, 32'(m << 1));
            wr(1, 32'hC3A50F12);
            rd("R10 din reads zero", 1);
        end
        wr(1, 32'h00000001);

        // R9 DMA request
        wr(0, 32'h08);
        cyc(1'b0, 0, '0, 1'b0, '0, 1'b1);
        idle();
        cyc(1'b0, 0, '0, 1'b0, '0, 1'b1);
        for (int n = 0; n < 4; n++) wr(1, 32'h100 + n);
        idle();
        cyc(1'b0, 0, '0, 1'b0, '0, 1'b1);
        wr(1, 32'h1);
        wr(0, 32'h00);
        idle();
        wr(0, 32'h08);
        for (int n = 0; n < 3; n++) wr(1, 32'h200 + n);
        idle();
        // request ignored while DMA disabled
        wr(0, 32'h00);
        cyc(1'b0, 0, '0, 1'b0, '0, 1'b1);
        wr(0, 32'h08);
        idle();

        // R10 unmapped writes ignored, full read sweep
        wr(5, 32'hFFFFFFFF);
        wr(40, 32'hFFFFFFFF);
        wr(20, 32'hFFFFFFFF);
        for (int a = 0; a < 64; a++) rd("R10 address sweep", a);

        idle();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule